// File: doc/BRIEF.md
# Audio Sample FIFO Pair with Status and Masked Interrupt

This block sits between a processor register interface and the serializer of a serial PCM audio port. It holds two sample queues: a transmit queue that the processor fills and the serializer drains, and a receive queue that the serializer fills and the processor drains. Each queue reports a fill count and four level flags. These are packed into one FIFO status word that software can read.

Underrun events are latched as sticky error bits: a pop from an empty queue is a starve, and a push into a full queue is an overflow. The same applies to a one-cycle transfer-done event. Software clears each sticky bit by writing 1 to it. The live level flags, the sticky bits and a pending summary bit form the interrupt status word. An interrupt control word enables each source on its own, using the same bit positions, and holds a global enable that forwards the pending summary to the processor's interrupt line.

While the port is disabled, the processor can also read the transmit data register. Each such read discards the oldest transmit sample, which lets software flush the queue.

Top module: `audio_fifo_irq_unit`

## Requirements
- R1: After reset both fill counts are 0, both empty and almost-empty flags are 1, the other flags and all sticky bits are 0, the interrupt control word reads 0 and `irq` is 0.
- R2: Each queue returns samples in the order written. The transmit fill count appears in `fifo_stat[18:14]` and the receive fill count in `fifo_stat[9:4]`.
- R3: Each queue holds 16 samples. A push into a full queue is dropped, leaving the count at 16 and the stored samples unchanged, and it sets that queue's sticky overflow bit.
- R4: A pop from an empty queue returns 0 on the read data output, leaves the pointers and count unchanged, and sets that queue's sticky starve bit.
- R5: The almost-empty flag is 1 when the count is 4 or fewer. The almost-full flag is 1 when the count is 12 or more.
- R6: In `fifo_stat`, transmit flags occupy bits 3:0 and receive flags occupy bits 13:10, in the order empty (lowest), almost empty, full, almost full.
- R7: `cpu_tx_rd` pops one transmit sample when `port_en` is 0, and it has no effect when `port_en` is 1.
- R8: Writing 1 to a sticky bit through `irq_clr_wr`/`irq_clr_wdata` clears it, and writing 0 leaves it unchanged. A new event in the same cycle as its clear leaves the bit set.
- R9: `irq_stat` bit 0 is the pending summary and bit 1 is transfer done. Bits 7:2 carry the transmit sources and bits 13:8 the receive sources, each group ordered empty, almost empty, full, almost full, starve, overflow from low to high. Pending is 1 when any source bit is 1 together with its enable bit in `irq_ctl`.
- R10: `irq_ctl_wr` loads `irq_ctl`. Bit 0 of `irq_ctl` is the global enable, and `irq` equals pending AND that bit.
- R11: The level-flag bits in `irq_stat` follow the live queue state and drop as soon as the condition ends, while the sticky bits stay set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_en | input | 1 | Port enabled; blocks processor reads of the transmit queue |
| cpu_tx_wr | input | 1 | Processor writes one transmit sample |
| cpu_tx_wdata | input | 16 | Transmit sample to write |
| cpu_tx_rd | input | 1 | Processor reads (pops) the transmit data register |
| cpu_tx_rdata | output | 16 | Oldest transmit sample, 0 when empty |
| cpu_rx_rd | input | 1 | Processor pops one receive sample |
| cpu_rx_rdata | output | 16 | Oldest receive sample, 0 when empty |
| ser_tx_pop | input | 1 | Serializer takes one transmit sample |
| ser_tx_data | output | 16 | Oldest transmit sample for the serializer, 0 when empty |
| ser_rx_push | input | 1 | Serializer delivers one receive sample |
| ser_rx_data | input | 16 | Received sample |
| xfer_done | input | 1 | One-cycle transfer-done event |
| irq_ctl_wr | input | 1 | Load the interrupt control word |
| irq_ctl_wdata | input | 14 | New interrupt control word |
| irq_clr_wr | input | 1 | Write-1-to-clear strobe for sticky bits |
| irq_clr_wdata | input | 14 | Clear mask, in interrupt status positions |
| fifo_stat | output | 19 | Fill counts and level flags of both queues |
| irq_stat | output | 14 | Interrupt status word |
| irq_ctl | output | 14 | Interrupt control readback |
| irq | output | 1 | Interrupt to the processor |

## Verification
The hardest case to reach from the ports is a sticky bit that is set and cleared in the same cycle. The stimulus reaches it by popping the empty transmit queue in the same cycle as a write-1-to-clear of the transmit starve bit, and then checks that the bit is still set. Overflow needs a queue pushed to exactly 16 entries before the dropped 17th write. The bench then drains all 16 samples to show that the dropped write left the stored data intact. The disabled-port read path is driven with `port_en` high and then low on the same queue contents, so that the blocked read and the real pop can be told apart by count and data.

// File: rtl/audio_fifo_pkg.sv
package audio_fifo_pkg;
  localparam int IRQ_W      = 14;
  localparam int IB_PEND    = 0;
  localparam int IB_DONE    = 1;
  localparam int IB_TX_BASE = 2;
  localparam int IB_RX_BASE = 8;
  localparam int OFF_EMPTY  = 0;
  localparam int OFF_AEMPTY = 1;
  localparam int OFF_FULL   = 2;
  localparam int OFF_AFULL  = 3;
  localparam int OFF_STARVE = 4;
  localparam int OFF_OVF    = 5;
  localparam int RXC_FW     = 6;
  localparam int FS_RXC_LSB = 4;
  localparam int FS_RXF_LSB = 10;
  localparam int FS_TXC_LSB = 14;

  typedef struct packed {
    logic afull;
    logic full;
    logic aempty;
    logic empty;
  } lvl_t;
endpackage

// File: rtl/sample_fifo.sv
module sample_fifo
  import audio_fifo_pkg::*;
#(
  parameter int W      = 16,
  parameter int DEPTH  = 16,
  parameter int AE_LVL = 4,
  parameter int AF_LVL = 12,
  parameter int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [W-1:0]     wdata,
  input  logic             pop,
  output logic [W-1:0]     rdata,
  output logic [CNT_W-1:0] count,
  output lvl_t             lvl,
  output logic             push_err,
  output logic             pop_err
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW-1:0]    LAST = AW'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [W-1:0]     mem [DEPTH];
  logic [AW-1:0]    wptr, wptr_n, rptr, rptr_n;
  logic [CNT_W-1:0] cnt_n;
  logic             do_push, do_pop;

  assign lvl.empty  = (count == '0);
  assign lvl.full   = (count == FULL_CNT);
  assign lvl.aempty = (count <= CNT_W'(AE_LVL));
  assign lvl.afull  = (count >= CNT_W'(AF_LVL));

  assign do_push  = push & ~lvl.full;
  assign do_pop   = pop & ~lvl.empty;
  assign push_err = push & lvl.full;
  assign pop_err  = pop & lvl.empty;
  assign rdata    = lvl.empty ? '0 : mem[rptr];

  always_comb begin
    wptr_n = wptr;
    rptr_n = rptr;
    cnt_n  = count;
    if (do_push) wptr_n = (wptr == LAST) ? '0 : wptr + 1'b1;
    if (do_pop)  rptr_n = (rptr == LAST) ? '0 : rptr + 1'b1;
    case ({do_push, do_pop})
      2'b10:   cnt_n = count + 1'b1;
      2'b01:   cnt_n = count - 1'b1;
      default: cnt_n = count;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else if (do_push || do_pop) begin
      wptr  <= wptr_n;
      rptr  <= rptr_n;
      count <= cnt_n;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= wdata;
  end
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import audio_fifo_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  lvl_t             tx_lvl,
  input  lvl_t             rx_lvl,
  input  logic             ev_done,
  input  logic             ev_tx_starve,
  input  logic             ev_tx_ovf,
  input  logic             ev_rx_starve,
  input  logic             ev_rx_ovf,
  input  logic             ctl_wr,
  input  logic [IRQ_W-1:0] ctl_wdata,
  input  logic             clr_wr,
  input  logic [IRQ_W-1:0] clr_wdata,
  output logic [IRQ_W-1:0] stat,
  output logic [IRQ_W-1:0] ctl,
  output logic             irq
);
  localparam int NSTK = 5;

  logic [NSTK-1:0]  sticky, sticky_n, set_v, clr_v;
  logic [IRQ_W-1:0] ctl_n, src;
  logic             pending;

  assign set_v = {ev_rx_ovf, ev_rx_starve, ev_tx_ovf, ev_tx_starve, ev_done};
  assign clr_v = clr_wr ? {clr_wdata[IB_RX_BASE + OFF_OVF],
                           clr_wdata[IB_RX_BASE + OFF_STARVE],
                           clr_wdata[IB_TX_BASE + OFF_OVF],
                           clr_wdata[IB_TX_BASE + OFF_STARVE],
                           clr_wdata[IB_DONE]} : '0;

  always_comb begin
    sticky_n = (sticky & ~clr_v) | set_v;
    ctl_n    = ctl_wr ? ctl_wdata : ctl;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sticky <= '0;
      ctl    <= '0;
    end else begin
      sticky <= sticky_n;
      ctl    <= ctl_n;
    end
  end

  always_comb begin
    src = '0;
    src[IB_DONE]                 = sticky[0];
    src[IB_TX_BASE + OFF_EMPTY]  = tx_lvl.empty;
    src[IB_TX_BASE + OFF_AEMPTY] = tx_lvl.aempty;
    src[IB_TX_BASE + OFF_FULL]   = tx_lvl.full;
    src[IB_TX_BASE + OFF_AFULL]  = tx_lvl.afull;
    src[IB_TX_BASE + OFF_STARVE] = sticky[1];
    src[IB_TX_BASE + OFF_OVF]    = sticky[2];
    src[IB_RX_BASE + OFF_EMPTY]  = rx_lvl.empty;
    src[IB_RX_BASE + OFF_AEMPTY] = rx_lvl.aempty;
    src[IB_RX_BASE + OFF_FULL]   = rx_lvl.full;
    src[IB_RX_BASE + OFF_AFULL]  = rx_lvl.afull;
    src[IB_RX_BASE + OFF_STARVE] = sticky[3];
    src[IB_RX_BASE + OFF_OVF]    = sticky[4];
    pending = |(src & ctl & ~(IRQ_W'(1) << IB_PEND));
    stat = src;
    stat[IB_PEND] = pending;
  end

  assign irq = pending & ctl[IB_PEND];
endmodule

// File: rtl/audio_fifo_irq_unit.sv
module audio_fifo_irq_unit
  import audio_fifo_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 16,
  parameter int AE_LVL = 4,
  parameter int AF_LVL = 12,
  parameter int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      port_en,
  input  logic                      cpu_tx_wr,
  input  logic [DATA_W-1:0]         cpu_tx_wdata,
  input  logic                      cpu_tx_rd,
  output logic [DATA_W-1:0]         cpu_tx_rdata,
  input  logic                      cpu_rx_rd,
  output logic [DATA_W-1:0]         cpu_rx_rdata,
  input  logic                      ser_tx_pop,
  output logic [DATA_W-1:0]         ser_tx_data,
  input  logic                      ser_rx_push,
  input  logic [DATA_W-1:0]         ser_rx_data,
  input  logic                      xfer_done,
  input  logic                      irq_ctl_wr,
  input  logic [IRQ_W-1:0]          irq_ctl_wdata,
  input  logic                      irq_clr_wr,
  input  logic [IRQ_W-1:0]          irq_clr_wdata,
  output logic [FS_TXC_LSB+CNT_W-1:0] fifo_stat,
  output logic [IRQ_W-1:0]          irq_stat,
  output logic [IRQ_W-1:0]          irq_ctl,
  output logic                      irq
);
  logic [DATA_W-1:0] tx_head;
  logic [CNT_W-1:0]  tx_cnt, rx_cnt;
  lvl_t              tx_lvl, rx_lvl;
  logic              tx_pop, tx_werr, tx_rerr, rx_werr, rx_rerr;

  assign tx_pop = ser_tx_pop | (cpu_tx_rd & ~port_en);

  sample_fifo #(.W(DATA_W), .DEPTH(DEPTH), .AE_LVL(AE_LVL), .AF_LVL(AF_LVL), .CNT_W(CNT_W)) u_txq (
    .clk(clk), .rst_n(rst_n), .push(cpu_tx_wr), .wdata(cpu_tx_wdata), .pop(tx_pop),
    .rdata(tx_head), .count(tx_cnt), .lvl(tx_lvl), .push_err(tx_werr), .pop_err(tx_rerr));

  sample_fifo #(.W(DATA_W), .DEPTH(DEPTH), .AE_LVL(AE_LVL), .AF_LVL(AF_LVL), .CNT_W(CNT_W)) u_rxq (
    .clk(clk), .rst_n(rst_n), .push(ser_rx_push), .wdata(ser_rx_data), .pop(cpu_rx_rd),
    .rdata(cpu_rx_rdata), .count(rx_cnt), .lvl(rx_lvl), .push_err(rx_werr), .pop_err(rx_rerr));

  assign ser_tx_data  = tx_head;
  assign cpu_tx_rdata = tx_head;

  always_comb begin
    fifo_stat = '0;
    fifo_stat[3:0] = tx_lvl;
    fifo_stat[FS_RXC_LSB +: RXC_FW] = RXC_FW'(rx_cnt);
    fifo_stat[FS_RXF_LSB +: 4] = rx_lvl;
    fifo_stat[FS_TXC_LSB +: CNT_W] = tx_cnt;
  end

  irq_ctrl u_irq (
    .clk(clk), .rst_n(rst_n), .tx_lvl(tx_lvl), .rx_lvl(rx_lvl), .ev_done(xfer_done),
    .ev_tx_starve(tx_rerr), .ev_tx_ovf(tx_werr), .ev_rx_starve(rx_rerr), .ev_rx_ovf(rx_werr),
    .ctl_wr(irq_ctl_wr), .ctl_wdata(irq_ctl_wdata), .clr_wr(irq_clr_wr), .clr_wdata(irq_clr_wdata),
    .stat(irq_stat), .ctl(irq_ctl), .irq(irq));
endmodule

// File: rtl/audio_fifo_irq_checker.sv
module audio_fifo_irq_checker
  import audio_fifo_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 16,
  parameter int CNT_W  = $clog2(DEPTH + 1)
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        port_en,
  input logic                        cpu_tx_wr,
  input logic                        cpu_tx_rd,
  input logic                        cpu_rx_rd,
  input logic [DATA_W-1:0]           cpu_rx_rdata,
  input logic                        ser_tx_pop,
  input logic                        irq_clr_wr,
  input logic [IRQ_W-1:0]            irq_clr_wdata,
  input logic [FS_TXC_LSB+CNT_W-1:0] fifo_stat,
  input logic [IRQ_W-1:0]            irq_stat,
  input logic [IRQ_W-1:0]            irq_ctl,
  input logic                        irq
);
  localparam int TXOVF = IB_TX_BASE + OFF_OVF;
  localparam int RXSTV = IB_RX_BASE + OFF_STARVE;

  logic [CNT_W-1:0] txc;
  logic             tx_full, rx_empty, any_tx_pop;
  assign txc        = fifo_stat[FS_TXC_LSB +: CNT_W];
  assign tx_full    = fifo_stat[OFF_FULL];
  assign rx_empty   = fifo_stat[FS_RXF_LSB + OFF_EMPTY];
  assign any_tx_pop = ser_tx_pop | (cpu_tx_rd & ~port_en);

  p_count_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    txc <= CNT_W'(DEPTH));
  p_full_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_tx_wr && tx_full && !any_tx_pop) |=> $stable(txc));
  p_ovf_latch_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_tx_wr && tx_full) |=> irq_stat[TXOVF]);
  p_empty_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_empty |-> (cpu_rx_rdata == '0));
  p_starve_latch_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rx_rd && rx_empty) |=> irq_stat[RXSTV]);
  p_rd_blocked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (port_en && cpu_tx_rd && !ser_tx_pop && !cpu_tx_wr) |=> $stable(txc));
  p_sticky_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_stat[TXOVF] && !(irq_clr_wr && irq_clr_wdata[TXOVF])) |=> irq_stat[TXOVF]);
  p_irq_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (irq_ctl[IB_PEND] && irq_stat[IB_PEND]));
endmodule

bind audio_fifo_irq_unit audio_fifo_irq_checker #(.DATA_W(DATA_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/tb_audio_fifo_irq_unit.sv
module tb_audio_fifo_irq_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        port_en, cpu_tx_wr, cpu_tx_rd, cpu_rx_rd, ser_tx_pop, ser_rx_push, xfer_done;
  logic [15:0] cpu_tx_wdata, ser_rx_data, cpu_tx_rdata, cpu_rx_rdata, ser_tx_data;
  logic        irq_ctl_wr, irq_clr_wr, irq;
  logic [13:0] irq_ctl_wdata, irq_clr_wdata, irq_stat, irq_ctl;
  logic [18:0] fifo_stat;
  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  audio_fifo_irq_unit dut (.*);

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step(); @(posedge clk); #1; endtask
  function automatic int txc(); return int'(fifo_stat[18:14]); endfunction
  function automatic int rxc(); return int'(fifo_stat[9:4]); endfunction

  task automatic tx_write(input logic [15:0] v);
    cpu_tx_wr = 1; cpu_tx_wdata = v; step(); cpu_tx_wr = 0;
  endtask
  task automatic tx_ser_pop(); ser_tx_pop = 1; step(); ser_tx_pop = 0; endtask
  task automatic rx_push(input logic [15:0] v);
    ser_rx_push = 1; ser_rx_data = v; step(); ser_rx_push = 0;
  endtask
  task automatic rx_read(); cpu_rx_rd = 1; step(); cpu_rx_rd = 0; endtask
  task automatic clr(input logic [13:0] m);
    irq_clr_wr = 1; irq_clr_wdata = m; step(); irq_clr_wr = 0;
  endtask

  task automatic t_reset();
    chk("R1", "tx count", txc(), 0);
    chk("R1", "rx count", rxc(), 0);
    chk("R6", "tx flags", int'(fifo_stat[3:0]), 3);
    chk("R6", "rx flags", int'(fifo_stat[13:10]), 3);
    chk("R9", "irq_stat", int'(irq_stat), 'h030C);
    chk("R1", "irq_ctl", int'(irq_ctl), 0);
    chk("R1", "irq", int'(irq), 0);
  endtask

  task automatic t_tx_order();
    for (int i = 0; i < 5; i++) tx_write(16'hA000 + 16'(i));
    chk("R2", "tx count 5", txc(), 5);
    chk("R5", "aempty at 5", int'(fifo_stat[1]), 0);
    for (int i = 0; i < 5; i++) begin
      chk("R2", "tx order", int'(ser_tx_data), 'hA000 + i);
      tx_ser_pop();
      if (i == 0) chk("R5", "aempty at 4", int'(fifo_stat[1]), 1);
    end
    chk("R2", "tx drained", txc(), 0);
  endtask

  task automatic t_tx_fill();
    for (int i = 0; i < 16; i++) begin
      tx_write(16'h5000 + 16'(i));
      if (i == 10) chk("R5", "afull at 11", int'(fifo_stat[3]), 0);
      if (i == 11) chk("R5", "afull at 12", int'(fifo_stat[3]), 1);
    end
    chk("R3", "tx count full", txc(), 16);
    chk("R6", "tx full flag", int'(fifo_stat[2]), 1);
    chk("R9", "tx full src", int'(irq_stat[4]), 1);
    chk("R3", "no ovf yet", int'(irq_stat[7]), 0);
    tx_write(16'hDEAD);
    chk("R3", "count after drop", txc(), 16);
    chk("R3", "tx overflow sticky", int'(irq_stat[7]), 1);
    for (int i = 0; i < 16; i++) begin
      chk("R3", "data after drop", int'(ser_tx_data), 'h5000 + i);
      tx_ser_pop();
    end
    chk("R11", "full src live", int'(irq_stat[4]), 0);
    chk("R11", "ovf stays", int'(irq_stat[7]), 1);
  endtask

  task automatic t_w1c();
    clr(14'h0000);
    chk("R8", "zero write keeps", int'(irq_stat[7]), 1);
    clr(14'h0080);
    chk("R8", "one write clears", int'(irq_stat[7]), 0);
    chk("R4", "tx empty data", int'(ser_tx_data), 0);
    ser_tx_pop = 1; irq_clr_wr = 1; irq_clr_wdata = 14'h0040; step();
    ser_tx_pop = 0; irq_clr_wr = 0;
    chk("R8", "set beats clear", int'(irq_stat[6]), 1);
    chk("R4", "tx count after starve", txc(), 0);
    clr(14'h0040);
    chk("R8", "starve cleared", int'(irq_stat[6]), 0);
  endtask

  task automatic t_cpu_tx_read();
    tx_write(16'h1111); tx_write(16'h2222);
    port_en = 1; cpu_tx_rd = 1; step(); cpu_tx_rd = 0;
    chk("R7", "blocked read count", txc(), 2);
    chk("R7", "blocked read head", int'(cpu_tx_rdata), 'h1111);
    port_en = 0; cpu_tx_rd = 1; step(); cpu_tx_rd = 0;
    chk("R7", "disabled read count", txc(), 1);
    chk("R7", "disabled read head", int'(cpu_tx_rdata), 'h2222);
    tx_ser_pop();
  endtask

  task automatic t_rx();
    chk("R4", "rx empty data", int'(cpu_rx_rdata), 0);
    rx_read();
    chk("R4", "rx count after starve", rxc(), 0);
    chk("R4", "rx starve sticky", int'(irq_stat[12]), 1);
    for (int i = 0; i < 3; i++) rx_push(16'hC000 + 16'(i));
    chk("R2", "rx count 3", rxc(), 3);
    for (int i = 0; i < 3; i++) begin
      chk("R2", "rx order", int'(cpu_rx_rdata), 'hC000 + i);
      rx_read();
    end
    for (int i = 0; i < 17; i++) rx_push(16'h7000 + 16'(i));
    chk("R3", "rx count full", rxc(), 16);
    chk("R6", "rx full flag", int'(fifo_stat[12]), 1);
    chk("R6", "rx afull flag", int'(fifo_stat[13]), 1);
    chk("R3", "rx overflow sticky", int'(irq_stat[13]), 1);
    for (int i = 0; i < 16; i++) begin
      chk("R3", "rx data after drop", int'(cpu_rx_rdata), 'h7000 + i);
      rx_read();
    end
    clr(14'h3000);
    chk("R8", "rx sticky cleared", int'(irq_stat[13:12]), 0);
  endtask

  task automatic t_irq();
    clr(14'h3FFE);
    irq_ctl_wr = 1; irq_ctl_wdata = 14'h0004; step(); irq_ctl_wr = 0;
    chk("R10", "ctl readback", int'(irq_ctl), 4);
    chk("R9", "pending tx empty", int'(irq_stat[0]), 1);
    chk("R10", "irq gated", int'(irq), 0);
    irq_ctl_wr = 1; irq_ctl_wdata = 14'h0005; step(); irq_ctl_wr = 0;
    chk("R10", "irq enabled", int'(irq), 1);
    tx_write(16'h0BEE);
    chk("R9", "pending off", int'(irq_stat[0]), 0);
    chk("R10", "irq off", int'(irq), 0);
    irq_ctl_wr = 1; irq_ctl_wdata = 14'h0003; step(); irq_ctl_wr = 0;
    xfer_done = 1; step(); xfer_done = 0;
    chk("R9", "done bit", int'(irq_stat[1]), 1);
    chk("R10", "irq on done", int'(irq), 1);
    clr(14'h0002);
    chk("R10", "irq after done clear", int'(irq), 0);
    tx_ser_pop();
  endtask

  initial begin
    rst_n = 0; port_en = 0; cpu_tx_wr = 0; cpu_tx_rd = 0; cpu_rx_rd = 0;
    ser_tx_pop = 0; ser_rx_push = 0; xfer_done = 0; irq_ctl_wr = 0; irq_clr_wr = 0;
    cpu_tx_wdata = 0; ser_rx_data = 0; irq_ctl_wdata = 0; irq_clr_wdata = 0;
    repeat (3) step();
    rst_n = 1;
    step();
    t_reset();
    t_tx_order();
    t_tx_fill();
    t_w1c();
    t_cpu_tx_read();
    t_rx();
    t_irq();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual=expired expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule